// File: doc/BRIEF.md
# Two-Wire Bus Slave with General Call Response

This block is the slave side of a two-wire serial bus (I2C). It follows the bus clock and data lines through synchronizers and finds START, repeated START and STOP conditions. It shifts in the 7-bit address and the direction bit, and it responds when the address equals a programmable own address. It also responds to the general call address. After it responds, it receives bytes from the master or sends bytes supplied by the host. It pulls the data line low through an output-enable. It never drives the line high.

After each address or data byte, the block raises a flag toward the host and presents a status code for that event. It holds the bus clock low until the host clears the flag. During that pause the host reads the received byte or supplies the next byte to send. The host also controls an acknowledge-enable input. Master mode, arbitration, 10-bit addressing and a register bus are not part of the block.

Top module: `i2c_gc_slave`

## Requirements
- R1: After reset, irqFlag=0, status=0xF8, sdaOe=0, sclOe=0 and rxData=0.
- R2: A START followed by the own address with direction bit 0, while ackEn=1, is acknowledged in the 9th clock (SDA low). After that clock falls, irqFlag=1 and status=0x60.
- R3: Address 7'b0000000 with direction bit 0 (general call) is acknowledged, and status=0x70. The same address with direction bit 1 is not acknowledged and raises no flag.
- R4: The own address with direction bit 1 is acknowledged, and status=0xA8. After the host clears the flag, the block sends txData on SDA, MSB first.
- R5: An address that does not match is not acknowledged and raises no flag. Bytes that follow it without a new START are ignored, even if they equal the own address.
- R6: While ackEn=0, the own address is not acknowledged, no flag is raised, and the block stays idle until the next START.
- R7: In receive mode, each byte is placed in rxData, MSB first. With ackEn=1 the byte is acknowledged and status=0x80. With ackEn=0 it is not acknowledged, status=0x88, and later bytes are ignored until a START.
- R8: In transmit mode, a master acknowledge gives status=0xB8, and the next txData is sent after the flag is cleared. A master not-acknowledge gives status=0xC0. SDA is then released and stays released until a STOP.
- R9: A STOP or repeated START that arrives while the block is addressed raises irqFlag with status=0xA0 and does not hold SCL. A repeated START begins a new address phase.
- R10: A START or STOP in the middle of a byte abandons that byte, releases SDA and returns the block to address detection.
- R11: sclOe stays high while a flag for a byte event is pending. It falls within two cycles of a flagClr pulse.
- R12: sdaOe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sclOe | output | 1 | 1 pulls the clock line low (stretch) |
| sdaOe | output | 1 | 1 pulls the data line low |
| ownAddr | input | 7 | Programmable own 7-bit address |
| ackEn | input | 1 | Permits acknowledging addresses and received bytes |
| txData | input | 8 | Byte to send, taken when the flag is cleared in transmit mode |
| rxData | output | 8 | Last byte received |
| irqFlag | output | 1 | Event flag toward the host |
| status | output | 8 | Code of the last flagged event |
| flagClr | input | 1 | One-cycle pulse that clears irqFlag |

## Verification
A wrong state or a wrong bit count shows up on the bus within one bit time. An acknowledge lands in the wrong clock, a data bit is shifted by one, or no acknowledge appears. The master model samples each of these at the middle of the SCL high phase. A wrong transition after an address or a data byte shows up one bit later as an unexpected status code, a missing flag, or a flag on traffic that should be ignored. The scoreboard compares each flag against its queue when the flag rises. A wrong hold or release of SCL either hangs the next bit or removes the pause, and the checks just after each flag catch it.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_WAIT_STOP
  } slvState_e;

  localparam logic [7:0] ST_OWN_W   = 8'h60;
  localparam logic [7:0] ST_GC_W    = 8'h70;
  localparam logic [7:0] ST_RX_ACK  = 8'h80;
  localparam logic [7:0] ST_RX_NACK = 8'h88;
  localparam logic [7:0] ST_END     = 8'hA0;
  localparam logic [7:0] ST_OWN_R   = 8'hA8;
  localparam logic [7:0] ST_TX_ACK  = 8'hB8;
  localparam logic [7:0] ST_TX_NACK = 8'hC0;
  localparam logic [7:0] ST_NONE    = 8'hF8;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shift;
    logic load;
    logic latchRx;
    logic latchAck;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic byteDone;
    logic ownHit;
    logic gcHit;
    logic rw;
    logic txBit;
    logic mAck;
  } dpEvt_t;

endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-2:0] ownAddr,
  input  logic [DATA_W-1:0] txData,
  input  dpCtl_t            ctl,
  output dpEvt_t            evt,
  output logic [DATA_W-1:0] rxData
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [DATA_W-1:0] shReg, rxQ;
  logic [CNT_W-1:0]  bitCnt;
  logic              ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      rxQ    <= '0;
      bitCnt <= '0;
      ackQ   <= 1'b1;
    end else begin
      if (ctl.load)       shReg <= txData;
      else if (ctl.shift) shReg <= {shReg[DATA_W-2:0], sdaS};
      if (ctl.clrCnt)     bitCnt <= '0;
      else if (evt.sclRise && bitCnt != CNT_W'(DATA_W)) bitCnt <= bitCnt + 1'b1;
      if (ctl.latchRx)    rxQ  <= shReg;
      if (ctl.latchAck)   ackQ <= sdaS;
    end
  end

  always_comb begin
    evt.start    = sclS && sclPrev && sdaPrev && !sdaS;
    evt.stop     = sclS && sclPrev && !sdaPrev && sdaS;
    evt.sclRise  = sclS && !sclPrev;
    evt.sclFall  = !sclS && sclPrev;
    evt.byteDone = (bitCnt == CNT_W'(DATA_W));
    evt.ownHit   = (shReg[DATA_W-1:1] == ownAddr);
    evt.gcHit    = (shReg[DATA_W-1:1] == '0) && !shReg[0];
    evt.rw       = shReg[0];
    evt.txBit    = shReg[DATA_W-1];
    evt.mAck     = !ackQ;
  end

  assign rxData = rxQ;
endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackEn,
  input  logic       flagClr,
  input  dpEvt_t     evt,
  output dpCtl_t     ctl,
  output logic       sdaOe,
  output logic       sclOe,
  output logic       irqFlag,
  output logic [7:0] status
);
  slvState_e state;
  logic flagQ, holdQ, ackDrvQ, txActQ, rdQ, gcQ, ackedQ;
  logic [7:0] statusQ;
  logic clrEv, addressed;

  assign clrEv     = flagClr && flagQ;
  assign addressed = state inside {S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_WAIT_STOP};

  always_comb begin
    ctl.load     = clrEv && state == S_TX && !txActQ;
    ctl.shift    = (evt.sclRise && (state == S_ADDR || state == S_RX) && !evt.byteDone) ||
                   (evt.sclFall && state == S_TX && txActQ && !evt.byteDone);
    ctl.clrCnt   = evt.start || ctl.load ||
                   (evt.sclFall && (state == S_ADDR_ACK || state == S_RX_ACK));
    ctl.latchRx  = evt.sclFall && state == S_RX && evt.byteDone;
    ctl.latchAck = evt.sclRise && state == S_TX_ACK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      flagQ   <= 1'b0;
      holdQ   <= 1'b0;
      statusQ <= ST_NONE;
      ackDrvQ <= 1'b0;
      txActQ  <= 1'b0;
      rdQ     <= 1'b0;
      gcQ     <= 1'b0;
      ackedQ  <= 1'b0;
    end else begin
      if (clrEv) begin
        flagQ <= 1'b0;
        holdQ <= 1'b0;
      end
      if (evt.start || evt.stop) begin
        if (addressed) begin
          flagQ   <= 1'b1;
          holdQ   <= 1'b0;
          statusQ <= ST_END;
        end
        ackDrvQ <= 1'b0;
        txActQ  <= 1'b0;
        state   <= evt.start ? S_ADDR : S_IDLE;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_ADDR:
            if (evt.sclFall && evt.byteDone) begin
              if (ackEn && (evt.ownHit || evt.gcHit)) begin
                ackDrvQ <= 1'b1;
                rdQ     <= evt.rw;
                gcQ     <= evt.gcHit;
                state   <= S_ADDR_ACK;
              end else begin
                state <= S_IDLE;
              end
            end
          S_ADDR_ACK:
            if (evt.sclFall) begin
              ackDrvQ <= 1'b0;
              flagQ   <= 1'b1;
              holdQ   <= 1'b1;
              statusQ <= rdQ ? ST_OWN_R : (gcQ ? ST_GC_W : ST_OWN_W);
              state   <= rdQ ? S_TX : S_RX;
            end
          S_RX:
            if (evt.sclFall && evt.byteDone) begin
              ackDrvQ <= ackEn;
              ackedQ  <= ackEn;
              state   <= S_RX_ACK;
            end
          S_RX_ACK:
            if (evt.sclFall) begin
              ackDrvQ <= 1'b0;
              flagQ   <= 1'b1;
              holdQ   <= 1'b1;
              statusQ <= ackedQ ? ST_RX_ACK : ST_RX_NACK;
              state   <= ackedQ ? S_RX : S_IDLE;
            end
          S_TX:
            if (ctl.load) begin
              txActQ <= 1'b1;
            end else if (evt.sclFall && evt.byteDone && txActQ) begin
              txActQ <= 1'b0;
              state  <= S_TX_ACK;
            end
          S_TX_ACK:
            if (evt.sclFall) begin
              flagQ   <= 1'b1;
              holdQ   <= 1'b1;
              statusQ <= evt.mAck ? ST_TX_ACK : ST_TX_NACK;
              state   <= evt.mAck ? S_TX : S_WAIT_STOP;
            end
          S_WAIT_STOP: ;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign sdaOe   = ackDrvQ || (txActQ && !evt.txBit);
  assign sclOe   = flagQ && holdQ;
  assign irqFlag = flagQ;
  assign status  = statusQ;
endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic [DATA_W-2:0] ownAddr,
  input  logic              ackEn,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData,
  output logic              irqFlag,
  output logic [7:0]        status,
  input  logic              flagClr
);
  dpCtl_t ctl;
  dpEvt_t evt;

  i2cs_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ownAddr(ownAddr),
    .txData(txData), .ctl(ctl), .evt(evt), .rxData(rxData)
  );

  i2cs_control uCtl (
    .clk(clk), .rstN(rstN), .ackEn(ackEn), .flagClr(flagClr), .evt(evt), .ctl(ctl),
    .sdaOe(sdaOe), .sclOe(sclOe), .irqFlag(irqFlag), .status(status)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       irqFlag,
  input logic [7:0] status,
  input logic       flagClr
);
  // R11: clock is stretched only while a flag is pending
  p_hold_needs_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> irqFlag);

  // R11: a clear of a held flag takes effect in the next cycle
  p_clear_drops_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && irqFlag && sclOe) |=> !irqFlag);

  // R12: data line is pulled or released only with the clock line low
  p_sda_pull_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);
  p_sda_release_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclIn);

  // R2: every raised flag carries a defined event code
  p_code_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> status inside {8'h60, 8'h70, 8'h80, 8'h88, 8'hA0, 8'hA8, 8'hB8, 8'hC0});

  // R8: the slave has let go of SDA whenever a flag appears
  p_flag_sda_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> !sdaOe);

  // R9: end-of-transfer event never stretches the clock
  p_end_no_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && status == 8'hA0) |-> !sclOe);
endmodule

bind i2c_gc_slave i2cs_checker uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sclOe(sclOe), .sdaOe(sdaOe),
  .irqFlag(irqFlag), .status(status), .flagClr(flagClr)
);

// File: tb/tb_i2c_gc_slave.sv
module tb_i2c_gc_slave;
  localparam int H = 8;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sclOe, sdaOe, irqFlag, flagClr = 1'b0, ackEn = 1'b1;
  logic [7:0] txData = 8'h00, rxData, status;
  logic sclBus, sdaBus;
  int checks = 0, errors = 0, sdaViol = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  assign sclBus = sclM & ~sclOe;
  assign sdaBus = sdaM & ~sdaOe;

  i2c_gc_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus), .sclOe(sclOe), .sdaOe(sdaOe),
    .ownAddr(OWN), .ackEn(ackEn), .txData(txData), .rxData(rxData),
    .irqFlag(irqFlag), .status(status), .flagClr(flagClr)
  );

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic expectCode(input logic [7:0] code, input string tag);
    expQ.push_back(code);
    tagQ.push_back(tag);
  endtask

  // scoreboard monitor: compares each raised flag with the queue
  logic flagPrev = 1'b0, sdaOePrev = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (irqFlag && !flagPrev) begin
        if (expQ.size() == 0) check(1'b0, "unexpected flag (R5/R6/R3)", status, 0);
        else begin
          automatic logic [7:0] e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(status == e, {t, " status code"}, status, e);
        end
      end
      if (sdaOe !== sdaOePrev && sclBus) sdaViol++;
    end
    flagPrev  = irqFlag;
    sdaOePrev = sdaOe;
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaM = b; waitCyc(H);
    sclM = 1'b1; @(negedge clk);
    while (!sclBus) @(negedge clk);
    waitCyc(H / 2); s = sdaBus; waitCyc(H / 2);
    sclM = 1'b0; waitCyc(H);
  endtask

  task automatic mStart();
    sdaM = 1'b0; waitCyc(H);
    sclM = 1'b0; waitCyc(H);
  endtask

  task automatic mRestart();
    sdaM = 1'b1; waitCyc(H);
    sclM = 1'b1; waitCyc(H);
    sdaM = 1'b0; waitCyc(H);
    sclM = 1'b0; waitCyc(H);
  endtask

  task automatic mStop();
    sdaM = 1'b0; waitCyc(H);
    sclM = 1'b1; @(negedge clk);
    while (!sclBus) @(negedge clk);
    waitCyc(H);
    sdaM = 1'b1; waitCyc(H * 2);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    ack = !s;
  endtask

  task automatic sendBits(input int n, input logic [7:0] v);
    logic s;
    for (int i = 0; i < n; i++) clockBit(v[7-i], s);
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      v[i] = s;
    end
    clockBit(!mAck, s);
  endtask

  task automatic serviceFlag(input string tag, input logic [7:0] tx, input bit held);
    check(irqFlag == 1'b1, {tag, " flag set"}, irqFlag, 1);
    check(sclOe == held, {"R11 hold while flagged ", tag}, sclOe, held);
    txData = tx;
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
    waitCyc(2);
    check(irqFlag == 1'b0 && sclOe == 1'b0, {"R11 release after clear ", tag}, {irqFlag, sclOe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);
    // R1 reset state
    check(!irqFlag && status == 8'hF8 && !sdaOe && !sclOe && rxData == 8'h00,
          "R1 reset state", {irqFlag, status, sdaOe, sclOe}, 12'h0F8 << 2);
    waitCyc(H);

    // R2, R7: own write, one acked byte, one not-acked byte, then ignored byte
    mStart();
    expectCode(8'h60, "R2");
    sendByte({OWN, 1'b0}, ack);
    check(ack, "R2 own address acknowledged", ack, 1);
    serviceFlag("R2", 8'h00, 1'b1);
    expectCode(8'h80, "R7");
    sendByte(8'hC5, ack);
    check(ack, "R7 data acknowledged", ack, 1);
    check(rxData == 8'hC5, "R7 rxData first byte", rxData, 8'hC5);
    serviceFlag("R7", 8'h00, 1'b1);
    ackEn = 1'b0;
    expectCode(8'h88, "R7");
    sendByte(8'h3C, ack);
    check(!ack, "R7 data not acknowledged with ackEn low", ack, 0);
    check(rxData == 8'h3C, "R7 rxData on nack", rxData, 8'h3C);
    serviceFlag("R7", 8'h00, 1'b1);
    ackEn = 1'b1;
    sendByte(8'h11, ack);
    check(!ack && !irqFlag, "R7 bytes after nack ignored", {ack, irqFlag}, 0);
    mStop();
    check(!irqFlag, "R7 stop after nack raises nothing", irqFlag, 0);

    // R3, R9: general call write then STOP
    mStart();
    expectCode(8'h70, "R3");
    sendByte(8'h00, ack);
    check(ack, "R3 general call acknowledged", ack, 1);
    serviceFlag("R3", 8'h00, 1'b1);
    expectCode(8'h80, "R3");
    sendByte(8'h81, ack);
    check(ack && rxData == 8'h81, "R3 general call data", rxData, 8'h81);
    serviceFlag("R3", 8'h00, 1'b1);
    expectCode(8'hA0, "R9");
    mStop();
    serviceFlag("R9", 8'h00, 1'b0);

    // R3: general call with read bit ignored
    mStart();
    sendByte(8'h01, ack);
    check(!ack && !irqFlag, "R3 general call read ignored", {ack, irqFlag}, 0);
    mStop();

    // R5: other address, then own address without START
    mStart();
    sendByte({7'h3B, 1'b0}, ack);
    check(!ack && !irqFlag, "R5 mismatch not acknowledged", {ack, irqFlag}, 0);
    sendByte({OWN, 1'b0}, ack);
    check(!ack && !irqFlag, "R5 own address without START ignored", {ack, irqFlag}, 0);
    mStop();

    // R6: ackEn low, own address
    ackEn = 1'b0;
    mStart();
    sendByte({OWN, 1'b0}, ack);
    check(!ack && !irqFlag, "R6 own address not acknowledged", {ack, irqFlag}, 0);
    ackEn = 1'b1;
    sendByte({OWN, 1'b0}, ack);
    check(!ack && !irqFlag, "R6 idle until next START", {ack, irqFlag}, 0);
    mStop();

    // R4, R8: own read, two bytes, master nack, then STOP
    mStart();
    expectCode(8'hA8, "R4");
    sendByte({OWN, 1'b1}, ack);
    check(ack, "R4 own read address acknowledged", ack, 1);
    serviceFlag("R4", 8'hA5, 1'b1);
    expectCode(8'hB8, "R8");
    readByte(1'b1, v);
    check(v == 8'hA5, "R4 first byte sent MSB first", v, 8'hA5);
    serviceFlag("R8", 8'h3C, 1'b1);
    expectCode(8'hC0, "R8");
    readByte(1'b0, v);
    check(v == 8'h3C, "R8 next byte after ack", v, 8'h3C);
    check(!sdaOe, "R8 SDA released after master nack", sdaOe, 0);
    serviceFlag("R8", 8'h00, 1'b1);
    readByte(1'b0, v);
    check(v == 8'hFF && !irqFlag, "R8 slave silent until STOP", v, 8'hFF);
    expectCode(8'hA0, "R9");
    mStop();
    serviceFlag("R9", 8'h00, 1'b0);

    // R10: STOP in the middle of an address
    mStart();
    sendBits(4, {OWN, 1'b0});
    mStop();
    check(!irqFlag && !sdaOe, "R10 aborted address raises nothing", {irqFlag, sdaOe}, 0);

    // R10, R9: repeated START in the middle of a data byte
    mStart();
    expectCode(8'h60, "R10");
    sendByte({OWN, 1'b0}, ack);
    serviceFlag("R10", 8'h00, 1'b1);
    sendBits(3, 8'hFF);
    expectCode(8'hA0, "R9");
    mRestart();
    check(!sdaOe, "R10 SDA free after abort", sdaOe, 0);
    serviceFlag("R9", 8'h00, 1'b0);
    expectCode(8'h60, "R10");
    sendByte({OWN, 1'b0}, ack);
    check(ack, "R10 address after repeated START", ack, 1);
    serviceFlag("R10", 8'h00, 1'b1);
    expectCode(8'h80, "R10");
    sendByte(8'h5A, ack);
    check(ack && rxData == 8'h5A, "R10 full byte after abort", rxData, 8'h5A);
    serviceFlag("R10", 8'h00, 1'b1);
    expectCode(8'hA0, "R9");
    mStop();
    serviceFlag("R9", 8'h00, 1'b0);

    waitCyc(H);
    check(expQ.size() == 0, "R2 all expected flags seen", expQ.size(), 0);
    check(sdaViol == 0, "R12 SDA changed only with SCL low", sdaViol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule